// File: doc/BRIEF.md
# Poison-Tagged Integer Register File

This block is the integer register file of a core that lets a compiler hoist loads and other fault-prone operations above the branches that guard them. Next to each 64-bit data word it keeps one extra tag bit, the poison bit. A hoisted (speculative) operation that hits a fault does not trap. It writes its destination with the poison bit set. A speculative operation that consumes a poisoned source writes a poisoned result, so the tag flows through dependent speculative code and no exception is taken on that path.

The fault becomes visible only when the value is actually needed. A read port marked non-speculative that touches a poisoned register raises the exception output. A read port marked as an explicit check raises it on a poisoned register and does nothing on a clean one. The exception output is registered and reports the lowest triggering read port and the register index it read. The trap machinery and the recovery code are outside the block. Register 0 is hard-wired to a clean zero.

Writers drive data, a speculative qualifier, a fault flag and a "sources poisoned" flag. Readers drive an address, a speculative qualifier and a check qualifier. Reads are combinational and show the contents before any write of the same cycle.

Top module: `prf_poison_rf`

## Requirements
- R1: While rst_ni is low and after it rises, every register reads with poison clear and exc_valid_o is 0.
- R2: A write that is non-speculative and non-faulting, or speculative with both fault and source-poison low, stores its data and clears the poison bit.
- R3: A speculative write with wr_fault_i high stores poison set and raises no exception.
- R4: A speculative write with wr_psrc_i high (poisoned source) stores poison set and raises no exception.
- R5: A non-speculative write with wr_fault_i high is dropped: the register keeps its previous data and poison.
- R6: rd_data_o and rd_psn_o show the addressed register in the same cycle. A write becomes visible from the next cycle, so a read of the same register in the write cycle returns the old contents.
- R7: Register 0 always reads data 0 with poison 0, every kind of write to it is ignored, and reading it never raises an exception.
- R8: A read with rd_en_i=1 and rd_spec_i=0 of a poisoned register sets exc_valid_o=1 in the next cycle, with exc_port_o giving the port number and exc_idx_o the register index. The same read with rd_spec_i=1 and rd_chk_i=0 raises nothing.
- R9: A read with rd_chk_i=1 raises the exception on a poisoned register whatever rd_spec_i is, and raises nothing on a clean register.
- R10: When several read ports trigger in one cycle, the lowest port number is reported. exc_valid_o is high only in cycles that follow a triggering cycle.
- R11: When several write ports target the same register in one cycle, the highest-numbered port decides both the data and the poison.
- R12: A read with rd_en_i=0 never raises the exception, even on a poisoned register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | NUM_WR | Write enable per port |
| wr_addr_i | input | NUM_WR x AW | Destination register per port |
| wr_data_i | input | NUM_WR x DATA_W | Write data per port |
| wr_spec_i | input | NUM_WR | Producer is speculative |
| wr_fault_i | input | NUM_WR | Producer hit a fault |
| wr_psrc_i | input | NUM_WR | Producer consumed a poisoned source |
| rd_en_i | input | NUM_RD | Read port carries a real consumer |
| rd_addr_i | input | NUM_RD x AW | Source register per port |
| rd_spec_i | input | NUM_RD | Consumer is speculative |
| rd_chk_i | input | NUM_RD | Consumer is an explicit check |
| rd_data_o | output | NUM_RD x DATA_W | Read data |
| rd_psn_o | output | NUM_RD | Poison bit of the read register |
| exc_valid_o | output | 1 | Deferred fault consumed (registered) |
| exc_port_o | output | PW | Reporting read port |
| exc_idx_o | output | AW | Register index that triggered |

## Verification
The bench goes after the tag's life cycle. It sets poison through a speculative fault and through propagation, then clears it with a clean overwrite. A design that failed to clear it would trap later on good data. Dropped non-speculative faulting writes are checked against the old contents, and register 0 is hit with faulting and clean writes. It also reads a register while writing it, to catch a file that forwards or loses the old contents. Colliding writes and multi-port triggers check the priority order, since a swapped order would report the wrong port or keep the wrong producer. Disabled, speculative and check reads of poisoned and clean registers separate trapping from silent consumption.

// File: rtl/prf_pkg.sv
package prf_pkg;

  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_CLEAN  = 2'd1,
    WR_POISON = 2'd2
  } wr_kind_e;

  // a non-speculative faulting producer never commits
  function automatic wr_kind_e wr_classify(input logic en, input logic spec,
                                           input logic fault, input logic psrc);
    if (!en) return WR_NONE;
    if (spec) return (fault || psrc) ? WR_POISON : WR_CLEAN;
    if (fault) return WR_NONE;
    return WR_CLEAN;
  endfunction

endpackage

// File: rtl/prf_bank.sv
module prf_bank
  import prf_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int DATA_W   = 64,
  parameter int NUM_WR   = 2,
  parameter int NUM_RD   = 2,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_kind_e          wr_kind_i [NUM_WR],
  input  logic [AW-1:0]     wr_addr_i [NUM_WR],
  input  logic [DATA_W-1:0] wr_data_i [NUM_WR],
  input  logic [AW-1:0]     rd_addr_i [NUM_RD],
  output logic [DATA_W-1:0] rd_data_o [NUM_RD],
  output logic              rd_psn_o  [NUM_RD]
);

  logic [DATA_W-1:0] dat_all [NUM_REGS];
  logic              psn_all [NUM_REGS];

  assign dat_all[0] = '0;
  assign psn_all[0] = 1'b0;

  for (genvar e = 1; e < NUM_REGS; e++) begin : g_ent
    logic              hit;
    logic              psn_n;
    logic [DATA_W-1:0] dat_n;
    logic              psn_q;
    logic [DATA_W-1:0] dat_q;

    // later ports override earlier ones
    always_comb begin
      hit   = 1'b0;
      psn_n = 1'b0;
      dat_n = '0;
      for (int p = 0; p < NUM_WR; p++) begin
        if (wr_kind_i[p] != WR_NONE && wr_addr_i[p] == AW'(e)) begin
          hit   = 1'b1;
          psn_n = (wr_kind_i[p] == WR_POISON);
          dat_n = wr_data_i[p];
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  psn_q <= 1'b0;
      else if (hit) psn_q <= psn_n;
    end

    always_ff @(posedge clk_i) begin
      if (hit) dat_q <= dat_n;
    end

    assign dat_all[e] = dat_q;
    assign psn_all[e] = psn_q;
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_data_o[r] = dat_all[rd_addr_i[r]];
    assign rd_psn_o[r]  = psn_all[rd_addr_i[r]];
  end

  p_poison_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind_i[NUM_WR-1] == WR_POISON && wr_addr_i[NUM_WR-1] != '0)
    |=> psn_all[$past(wr_addr_i[NUM_WR-1])]);

  p_clean_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind_i[NUM_WR-1] == WR_CLEAN && wr_addr_i[NUM_WR-1] != '0)
    |=> !psn_all[$past(wr_addr_i[NUM_WR-1])]);

endmodule

// File: rtl/prf_rd_port.sv
module prf_rd_port #(
  parameter int DATA_W = 64,
  parameter int AW     = 7
) (
  input  logic              en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              spec_i,
  input  logic              chk_i,
  input  logic [DATA_W-1:0] raw_data_i,
  input  logic              raw_psn_i,
  output logic [DATA_W-1:0] data_o,
  output logic              psn_o,
  output logic              trig_o
);

  logic is_r0;

  assign is_r0  = (addr_i == '0);
  assign data_o = is_r0 ? '0 : raw_data_i;
  assign psn_o  = raw_psn_i & ~is_r0;
  // speculative consumers absorb poison; checks and committed consumers trap
  assign trig_o = en_i & psn_o & (~spec_i | chk_i);

  always_comb begin
    if (is_r0) p_r0_clean_r7: assert (psn_o == 1'b0);
  end

endmodule

// File: rtl/prf_exc_unit.sv
module prf_exc_unit #(
  parameter int NUM_RD = 2,
  parameter int AW     = 7,
  localparam int PW    = (NUM_RD > 1) ? $clog2(NUM_RD) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_RD-1:0] trig_i,
  input  logic [AW-1:0]     idx_i [NUM_RD],
  output logic              exc_valid_o,
  output logic [PW-1:0]     exc_port_o,
  output logic [AW-1:0]     exc_idx_o
);

  logic          any_d;
  logic [PW-1:0] port_d;
  logic [AW-1:0] idx_d;

  always_comb begin
    any_d  = 1'b0;
    port_d = '0;
    idx_d  = '0;
    for (int r = NUM_RD - 1; r >= 0; r--) begin
      if (trig_i[r]) begin
        any_d  = 1'b1;
        port_d = PW'(r);
        idx_d  = idx_i[r];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_valid_o <= 1'b0;
      exc_port_o  <= '0;
      exc_idx_o   <= '0;
    end else begin
      exc_valid_o <= any_d;
      exc_port_o  <= port_d;
      exc_idx_o   <= idx_d;
    end
  end

  p_exc_from_trig_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> |($past(trig_i) & (NUM_RD'(1) << exc_port_o)));

  p_lowest_port_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> (($past(trig_i) & ((NUM_RD'(1) << exc_port_o) - NUM_RD'(1))) == '0));

  p_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i == '0) |=> !exc_valid_o);

endmodule

// File: rtl/prf_poison_rf.sv
module prf_poison_rf
  import prf_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int DATA_W   = 64,
  parameter int NUM_WR   = 2,
  parameter int NUM_RD   = 2,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int PW      = (NUM_RD > 1) ? $clog2(NUM_RD) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_WR-1:0]              wr_en_i,
  input  logic [NUM_WR-1:0][AW-1:0]      wr_addr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data_i,
  input  logic [NUM_WR-1:0]              wr_spec_i,
  input  logic [NUM_WR-1:0]              wr_fault_i,
  input  logic [NUM_WR-1:0]              wr_psrc_i,
  input  logic [NUM_RD-1:0]              rd_en_i,
  input  logic [NUM_RD-1:0][AW-1:0]      rd_addr_i,
  input  logic [NUM_RD-1:0]              rd_spec_i,
  input  logic [NUM_RD-1:0]              rd_chk_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o,
  output logic [NUM_RD-1:0]              rd_psn_o,
  output logic                           exc_valid_o,
  output logic [PW-1:0]                  exc_port_o,
  output logic [AW-1:0]                  exc_idx_o
);

  wr_kind_e          wkind [NUM_WR];
  logic [AW-1:0]     waddr [NUM_WR];
  logic [DATA_W-1:0] wdata [NUM_WR];
  logic [AW-1:0]     raddr [NUM_RD];
  logic [DATA_W-1:0] rraw  [NUM_RD];
  logic              rpsn  [NUM_RD];
  logic [NUM_RD-1:0] trig;

  for (genvar p = 0; p < NUM_WR; p++) begin : g_wr
    assign wkind[p] = wr_classify(wr_en_i[p], wr_spec_i[p], wr_fault_i[p], wr_psrc_i[p]);
    assign waddr[p] = wr_addr_i[p];
    assign wdata[p] = wr_data_i[p];
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rdaddr
    assign raddr[r] = rd_addr_i[r];
  end

  prf_bank #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_WR(NUM_WR), .NUM_RD(NUM_RD)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_kind_i (wkind),
    .wr_addr_i (waddr),
    .wr_data_i (wdata),
    .rd_addr_i (raddr),
    .rd_data_o (rraw),
    .rd_psn_o  (rpsn)
  );

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rp
    prf_rd_port #(.DATA_W(DATA_W), .AW(AW)) u_rp (
      .en_i       (rd_en_i[r]),
      .addr_i     (rd_addr_i[r]),
      .spec_i     (rd_spec_i[r]),
      .chk_i      (rd_chk_i[r]),
      .raw_data_i (rraw[r]),
      .raw_psn_i  (rpsn[r]),
      .data_o     (rd_data_o[r]),
      .psn_o      (rd_psn_o[r]),
      .trig_o     (trig[r])
    );
  end

  prf_exc_unit #(.NUM_RD(NUM_RD), .AW(AW)) u_exc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig),
    .idx_i       (raddr),
    .exc_valid_o (exc_valid_o),
    .exc_port_o  (exc_port_o),
    .exc_idx_o   (exc_idx_o)
  );

  p_spec_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_en_i & ~rd_spec_i) == '0 && rd_chk_i == '0) |=> !exc_valid_o);

endmodule

// File: tb/sim_prf_poison_rf.sv
`timescale 1ns/1ps
module sim_prf_poison_rf;

  localparam int NREG = 128;
  localparam int DW   = 64;
  localparam int NW   = 2;
  localparam int NR   = 2;
  localparam int AW   = $clog2(NREG);
  localparam int PW   = (NR > 1) ? $clog2(NR) : 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [NW-1:0]          wr_en, wr_spec, wr_fault, wr_psrc;
  logic [NW-1:0][AW-1:0]  wr_addr;
  logic [NW-1:0][DW-1:0]  wr_data;
  logic [NR-1:0]          rd_en, rd_spec, rd_chk;
  logic [NR-1:0][AW-1:0]  rd_addr;
  logic [NR-1:0][DW-1:0]  rd_data_o;
  logic [NR-1:0]          rd_psn_o;
  logic                   exc_valid_o;
  logic [PW-1:0]          exc_port_o;
  logic [AW-1:0]          exc_idx_o;

  prf_poison_rf #(.NUM_REGS(NREG), .DATA_W(DW), .NUM_WR(NW), .NUM_RD(NR)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wr_spec_i(wr_spec), .wr_fault_i(wr_fault), .wr_psrc_i(wr_psrc),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_spec_i(rd_spec), .rd_chk_i(rd_chk),
    .rd_data_o(rd_data_o), .rd_psn_o(rd_psn_o),
    .exc_valid_o(exc_valid_o), .exc_port_o(exc_port_o), .exc_idx_o(exc_idx_o)
  );

  typedef struct {
    bit    v;
    int    port;
    int    idx;
    string tag;
  } exp_t;

  exp_t exq[$];
  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] mdat [NREG];
  bit            mpsn [NREG];
  bit            mval [NREG];

  task automatic idle();
    wr_en = '0; wr_spec = '0; wr_fault = '0; wr_psrc = '0;
    wr_addr = '0; wr_data = '0;
    rd_en = '0; rd_spec = '0; rd_chk = '0; rd_addr = '0;
  endtask

  task automatic wr(input int p, input int a, input logic [DW-1:0] d,
                    input bit spec, input bit fault, input bit psrc);
    wr_en[p] = 1'b1; wr_addr[p] = AW'(a); wr_data[p] = d;
    wr_spec[p] = spec; wr_fault[p] = fault; wr_psrc[p] = psrc;
  endtask

  task automatic rd(input int p, input int a, input bit en, input bit spec, input bit chk);
    rd_en[p] = en; rd_addr[p] = AW'(a); rd_spec[p] = spec; rd_chk[p] = chk;
  endtask

  // check comb reads, queue the expected exception, advance the model, move to next cycle
  task automatic step(input string tag);
    exp_t e;
    e.v = 0; e.port = 0; e.idx = 0; e.tag = tag;
    #1;
    for (int r = 0; r < NR; r++) begin
      int a = int'(rd_addr[r]);
      bit ep = (a == 0) ? 1'b0 : mpsn[a];
      logic [DW-1:0] ed = (a == 0) ? '0 : mdat[a];
      checks++;
      if (rd_psn_o[r] !== ep) begin
        fails++;
        $display("FAIL %s poison port %0d reg %0d: got %b exp %b", tag, r, a, rd_psn_o[r], ep);
      end
      if (a == 0 || mval[a]) begin
        checks++;
        if (rd_data_o[r] !== ed) begin
          fails++;
          $display("FAIL %s data port %0d reg %0d: got %h exp %h", tag, r, a, rd_data_o[r], ed);
        end
      end
      if (!e.v && rd_en[r] && ep && (!rd_spec[r] || rd_chk[r])) begin
        e.v = 1; e.port = r; e.idx = a;
      end
    end
    exq.push_back(e);
    for (int p = 0; p < NW; p++) begin
      int a = int'(wr_addr[p]);
      if (wr_en[p] && a != 0) begin
        if (wr_spec[p]) begin
          mdat[a] = wr_data[p]; mval[a] = 1; mpsn[a] = wr_fault[p] | wr_psrc[p];
        end else if (!wr_fault[p]) begin
          mdat[a] = wr_data[p]; mval[a] = 1; mpsn[a] = 0;
        end
      end
    end
    @(negedge clk);
  endtask

  // monitor: registered exception of the previous cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exq.size() > 0) begin
        exp_t e;
        e = exq.pop_front();
        checks++;
        if (exc_valid_o !== e.v ||
            (e.v && (int'(exc_port_o) != e.port || int'(exc_idx_o) != e.idx))) begin
          fails++;
          $display("FAIL %s exception: got v=%b port=%0d idx=%0d exp v=%0d port=%0d idx=%0d",
                   e.tag, exc_valid_o, exc_port_o, exc_idx_o, e.v, e.port, e.idx);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin mdat[i] = '0; mpsn[i] = 0; mval[i] = 0; end
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (exc_valid_o !== 1'b0) begin
      fails++; $display("FAIL R1 exc during reset: got %b exp 0", exc_valid_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: poison clear after reset, non-spec reads do not trap
    idle(); rd(0, 5, 1, 0, 0); rd(1, 127, 1, 0, 1); step("R1");

    // R2: clean non-speculative fills
    for (int i = 1; i <= 8; i++) begin
      idle(); wr(0, i, 64'h1000 + i, 0, 0, 0); wr(1, i + 8, 64'hA5A5_0000_0000_0000 | i, 0, 0, 0);
      step("R2");
    end
    for (int i = 1; i <= 16; i += 2) begin
      idle(); rd(0, i, 1, 0, 0); rd(1, i + 1, 1, 0, 0); step("R6");
    end

    // R6: read in the write cycle returns old contents
    idle(); wr(0, 3, 64'hDEAD, 0, 0, 0); rd(0, 3, 1, 0, 0); step("R6");
    idle(); rd(1, 3, 1, 0, 0); step("R6");

    // R3: speculative fault poisons silently
    idle(); wr(1, 4, 64'hBAD4, 1, 1, 0); step("R3");
    idle(); rd(0, 4, 1, 1, 0); step("R3");
    // R8: committed consumer traps
    idle(); rd(0, 4, 1, 0, 0); step("R8");
    idle(); step("R8");

    // R4: propagation through speculative consumer
    idle(); wr(0, 5, 64'h55, 1, 0, 1); rd(1, 4, 1, 1, 0); step("R4");
    // R9: check on poisoned traps on port 1, check on clean is silent
    idle(); rd(1, 5, 1, 1, 1); rd(0, 6, 1, 0, 1); step("R9");
    idle(); rd(0, 6, 1, 1, 1); step("R9");

    // R5: non-speculative faulting write dropped, both clean and poisoned targets
    idle(); wr(0, 6, 64'hFFFF, 0, 1, 0); wr(1, 5, 64'hEEEE, 0, 1, 0); step("R5");
    idle(); rd(0, 6, 1, 1, 0); rd(1, 5, 1, 1, 0); step("R5");

    // R10: two triggers, lowest port wins, then the other, then idle
    idle(); rd(0, 4, 1, 0, 0); rd(1, 5, 1, 0, 0); step("R10");
    idle(); rd(1, 5, 1, 0, 0); step("R10");
    idle(); step("R10");
    idle(); rd(0, 2, 1, 0, 0); rd(1, 4, 1, 0, 1); step("R10");

    // R7: register 0
    idle(); wr(0, 0, 64'h1234, 0, 0, 0); wr(1, 0, 64'h9999, 1, 1, 0); step("R7");
    idle(); rd(0, 0, 1, 0, 1); rd(1, 0, 1, 0, 0); step("R7");

    // R11: colliding writes, highest port decides
    idle(); wr(0, 7, 64'h70, 1, 1, 0); wr(1, 7, 64'h71, 0, 0, 0); step("R11");
    idle(); rd(0, 7, 1, 0, 0); step("R11");
    idle(); wr(0, 7, 64'h72, 0, 0, 0); wr(1, 7, 64'h73, 1, 0, 1); step("R11");
    idle(); rd(1, 7, 1, 0, 0); step("R11");

    // R12: disabled reads never trap
    idle(); rd(0, 4, 0, 0, 0); rd(1, 7, 0, 0, 1); step("R12");
    idle(); step("R12");

    // R2: clean overwrites clear poison (non-spec and spec)
    idle(); wr(0, 4, 64'h4444, 0, 0, 0); wr(1, 5, 64'h5555, 1, 0, 0); step("R2");
    idle(); rd(0, 4, 1, 0, 0); rd(1, 5, 1, 0, 1); step("R2");

    // mixed sweep over the whole file
    for (int i = 0; i < 400; i++) begin
      int h = (i * 37 + 11) % NREG;
      int g = (i * 53 + 5) % NREG;
      idle();
      wr(i % NW, h, {32'(i), 32'(h * 977)}, (i % 3) != 0, (i % 5) == 0, (i % 7) == 0);
      rd(0, g, (i % 4) != 3, (i % 6) == 1, (i % 9) == 2);
      rd(1, (g + 3) % NREG, 1, (i % 2) == 0, (i % 8) == 5);
      step("R8");
    end
    idle(); step("R9");
    idle(); step("R10");

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule